// File: doc/BRIEF.md
# Ripple-Carry Arithmetic Logic Unit with Signed Compare

This block is a purely combinational 32-bit arithmetic logic unit. It is built from a row of identical one-bit cells, and the carry ripples from the least significant cell to the most significant one. It takes two operands and a 4-bit operation code. From these it produces a result word and three flags: zero, signed overflow and carry-out.

The same adder serves add, subtract and signed compare. For subtract and compare, the second operand is inverted in every cell and a carry of 1 enters the bottom cell. The top cell is a variant of the common cell. It forms the overflow indication from its own carry-in and carry-out. It also forms the corrected sign of the difference, which is routed back down to bit 0 as the compare answer.

A datapath uses the block by presenting operands and a code, then taking the outputs in the same cycle. Branch-on-equal is a subtract followed by a test of the zero flag.

Top module: `ripple_alu`

## Requirements
- R1: Code 0000 gives A AND B, 0001 gives A OR B, 1101 gives A XOR B and 1100 gives NOT (A OR B), all bit by bit.
- R2: Code 0010 gives the low 32 bits of A + B, and carry-out is bit 32 of that sum.
- R3: Code 0110 gives the low 32 bits of A - B. For codes 0110 and 0111, carry-out is 1 exactly when A is greater than or equal to B as unsigned numbers.
- R4: For codes 0010 and 0110, overflow is 1 exactly when the two's-complement result does not fit in 32 bits. For add, that is when both operands have the same sign and the sum's sign differs. For subtract, that is when the operands' signs differ and the difference's sign differs from A's.
- R5: Code 0111 puts 1 in bit 0 when A < B as signed numbers, even when A - B overflows. Bits 31 to 1 are always 0. The overflow flag reports the overflow of A - B.
- R6: Zero is 1 exactly when all 32 result bits are 0.
- R7: For the bitwise codes (0000, 0001, 1100, 1101) and for unused codes, overflow is 0. Carry-out is then bit 32 of A + B.
- R8: Any code other than the seven listed gives a result of 0, and therefore zero = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_code | input | 4 | Operation select |
| result | output | 32 | Operation result |
| zero | output | 1 | All result bits are 0 |
| overflow | output | 1 | Signed overflow of add, subtract or compare |
| carry_out | output | 1 | Carry from the top cell |

## Verification
Two functions of the top cell fall in the same evaluation: the overflow flag and the compare bit that is fed back to bit 0. The compare bit must use the overflow to correct the raw sign. This is provoked with compare operands of opposite signs whose difference wraps, such as the most negative value against 1 and the most positive value against -1. It is judged by checking that bit 0 follows the true signed order while the overflow flag is 1. Equal operands on subtract and compare also show whether the zero flag and the unsigned carry-out agree with each other in the same vector.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100,
        OP_XOR = 4'b1101
    } alu_op_e;

    typedef enum logic [2:0] {
        PICK_AND,
        PICK_OR,
        PICK_XOR,
        PICK_NOR,
        PICK_SUM,
        PICK_LESS,
        PICK_NONE
    } pick_e;

    typedef struct packed {
        logic  b_inv;
        logic  carry_seed;
        logic  arith;
        pick_e pick;
    } slice_ctrl_t;

    function automatic logic parity3(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

    function automatic logic majority3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    function automatic slice_ctrl_t decode_op(input logic [OP_W-1:0] code);
        slice_ctrl_t c;
        c.b_inv      = 1'b0;
        c.carry_seed = 1'b0;
        c.arith      = 1'b0;
        c.pick       = PICK_NONE;
        case (code)
            OP_AND: c.pick = PICK_AND;
            OP_OR:  c.pick = PICK_OR;
            OP_XOR: c.pick = PICK_XOR;
            OP_NOR: c.pick = PICK_NOR;
            OP_ADD: begin
                c.arith = 1'b1;
                c.pick  = PICK_SUM;
            end
            OP_SUB: begin
                c.b_inv      = 1'b1;
                c.carry_seed = 1'b1;
                c.arith      = 1'b1;
                c.pick       = PICK_SUM;
            end
            OP_SLT: begin
                c.b_inv      = 1'b1;
                c.carry_seed = 1'b1;
                c.arith      = 1'b1;
                c.pick       = PICK_LESS;
            end
            default: c.pick = PICK_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import ripple_alu_pkg::*;
(
    input  logic [OP_W-1:0] code,
    output slice_ctrl_t     ctrl
);
    always_comb ctrl = decode_op(code);

    always_comb begin
        // R3
        sub_inverts_chk: assert (!(ctrl.b_inv) || (ctrl.carry_seed && ctrl.arith))
            else $error("invert without carry seed");
    end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import ripple_alu_pkg::*;
#(
    parameter bit IS_TOP = 1'b0
) (
    input  logic        a,
    input  logic        b,
    input  logic        cin,
    input  logic        less,
    input  slice_ctrl_t ctrl,
    output logic        res,
    output logic        cout,
    output logic        set_out,
    output logic        ovf
);
    logic b_eff;
    logic sum;

    always_comb begin
        b_eff = b ^ ctrl.b_inv;
        sum   = parity3(a, b_eff, cin);
        cout  = majority3(a, b_eff, cin);
    end

    always_comb begin
        case (ctrl.pick)
            PICK_AND:  res = a & b;
            PICK_OR:   res = a | b;
            PICK_XOR:  res = a ^ b;
            PICK_NOR:  res = ~(a | b);
            PICK_SUM:  res = sum;
            PICK_LESS: res = less;
            default:   res = 1'b0;
        endcase
    end

    generate
        if (IS_TOP) begin : g_top
            logic wrap;
            always_comb begin
                wrap    = cin ^ cout;
                ovf     = wrap & ctrl.arith;
                set_out = sum ^ wrap;
            end
            always_comb begin
                // R4
                ovf_sign_chk: assert (!ovf || ((a == b_eff) && (sum != a)))
                    else $error("overflow with mismatched signs");
            end
        end else begin : g_plain
            always_comb begin
                ovf     = 1'b0;
                set_out = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] bits,
    output logic         all_clear
);
    always_comb all_clear = ~(|bits);
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import ripple_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [3:0]       op_code,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic             carry_out
);
    localparam int TOP = WIDTH - 1;

    slice_ctrl_t      ctrl;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] set_w;
    logic [WIDTH-1:0] ovf_w;
    logic             less_fb;

    alu_op_decode u_dec (
        .code (op_code),
        .ctrl (ctrl)
    );

    always_comb begin
        carry[0]  = ctrl.carry_seed;
        less_fb   = |set_w;
        overflow  = |ovf_w;
        carry_out = carry[WIDTH];
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            alu_bit_slice #(
                .IS_TOP (i == TOP)
            ) u_cell (
                .a       (opnd_a[i]),
                .b       (opnd_b[i]),
                .cin     (carry[i]),
                .less    ((i == 0) ? less_fb : 1'b0),
                .ctrl    (ctrl),
                .res     (result[i]),
                .cout    (carry[i+1]),
                .set_out (set_w[i]),
                .ovf     (ovf_w[i])
            );
        end
    endgenerate

    alu_zero_detect #(.W(WIDTH)) u_zero (
        .bits      (result),
        .all_clear (zero)
    );

    always_comb begin
        // R7
        no_overflow_chk: assert (ctrl.arith || !overflow)
            else $error("overflow on non-arithmetic code");
        // R8
        unused_code_chk: assert (ctrl.pick != PICK_NONE || (result == '0 && zero))
            else $error("unused code produced data");
        // R5
        slt_upper_chk: assert (ctrl.pick != PICK_LESS || result[WIDTH-1:1] == '0)
            else $error("compare set upper bits");
        // R3
        sub_borrow_chk: assert (op_code != 4'b0110 || carry_out == (opnd_a >= opnd_b))
            else $error("subtract carry not unsigned ge");
    end
endmodule

// File: tb/ripple_alu_bench.sv
module ripple_alu_bench;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  op;
        logic [31:0] res;
        logic        zr;
        logic        ov;
        logic        co;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  op_code = '0;
    logic [31:0] result;
    logic        zero;
    logic        overflow;
    logic        carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    ripple_alu u_ripple_alu (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .op_code   (op_code),
        .result    (result),
        .zero      (zero),
        .overflow  (overflow),
        .carry_out (carry_out)
    );

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
        exp_t e;
        logic [32:0] s;
        logic [32:0] d;
        s = {1'b0, a} + {1'b0, b};
        d = {1'b0, a} + {1'b0, ~b} + 33'd1;
        e.a = a; e.b = b; e.op = op;
        e.ov = 1'b0;
        e.co = s[32];
        case (op)
            4'b0000: begin e.res = a & b;    e.req = "R1"; end
            4'b0001: begin e.res = a | b;    e.req = "R1"; end
            4'b1101: begin e.res = a ^ b;    e.req = "R1"; end
            4'b1100: begin e.res = ~(a | b); e.req = "R1"; end
            4'b0010: begin
                e.res = s[31:0];
                e.ov  = (a[31] == b[31]) && (s[31] != a[31]);
                e.req = "R2";
            end
            4'b0110: begin
                e.res = d[31:0];
                e.ov  = (a[31] != b[31]) && (d[31] != a[31]);
                e.co  = (a >= b);
                e.req = "R3";
            end
            4'b0111: begin
                e.res = {31'd0, ($signed(a) < $signed(b))};
                e.ov  = (a[31] != b[31]) && (d[31] != a[31]);
                e.co  = (a >= b);
                e.req = "R5";
            end
            default: begin e.res = '0; e.req = "R8"; end
        endcase
        e.zr = (e.res == '0);
        return e;
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
        @(posedge clk);
        #1;
        opnd_a  = a;
        opnd_b  = b;
        op_code = op;
        sb.push_back(model(a, b, op));
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (result !== e.res) begin
                fails++;
                $display("FAIL %s result op=%b a=%h b=%h actual=%h expected=%h", e.req, e.op, e.a, e.b, result, e.res);
            end else if (zero !== e.zr) begin
                fails++;
                $display("FAIL R6 zero op=%b a=%h b=%h actual=%b expected=%b", e.op, e.a, e.b, zero, e.zr);
            end else if (overflow !== e.ov) begin
                fails++;
                $display("FAIL %s overflow op=%b a=%h b=%h actual=%b expected=%b",
                         (e.req == "R1" || e.req == "R8") ? "R7" : "R4", e.op, e.a, e.b, overflow, e.ov);
            end else if (carry_out !== e.co) begin
                fails++;
                $display("FAIL %s carry op=%b a=%h b=%h actual=%b expected=%b",
                         (e.req == "R1" || e.req == "R8") ? "R7" : e.req, e.op, e.a, e.b, carry_out, e.co);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] ops [7] = '{4'b0000, 4'b0001, 4'b1101, 4'b1100, 4'b0010, 4'b0110, 4'b0111};
        logic [3:0] bad [9] = '{4'b0011, 4'b0100, 4'b0101, 4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b1110, 4'b1111};
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // idle inputs: AND of zeros gives zero flag (R6)
        apply(32'h0, 32'h0, 4'b0000);
        // R1 bitwise patterns
        apply(32'hFFFF_0000, 32'h0F0F_0F0F, 4'b0000);
        apply(32'hFFFF_0000, 32'h0F0F_0F0F, 4'b0001);
        apply(32'hFFFF_0000, 32'h0F0F_0F0F, 4'b1101);
        apply(32'h0, 32'h0, 4'b1100);
        // R2 carry and R4 overflow on add
        apply(32'h7FFF_FFFF, 32'h1, 4'b0010);
        apply(32'hFFFF_FFFF, 32'h1, 4'b0010);
        apply(32'h8000_0000, 32'h8000_0000, 4'b0010);
        // R3 subtract: equal (R6 zero), borrow, overflow
        apply(32'h1234_5678, 32'h1234_5678, 4'b0110);
        apply(32'h1, 32'h2, 4'b0110);
        apply(32'h8000_0000, 32'h1, 4'b0110);
        // R5 compare with overflow in both directions
        apply(32'h8000_0000, 32'h1, 4'b0111);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
        apply(32'hFFFF_FFFF, 32'h0, 4'b0111);
        apply(32'h5, 32'h5, 4'b0111);
        // R7 carry on logical code with overflow-prone operands
        apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'b0001);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1101);
        // R8 unused codes
        foreach (bad[k]) apply(32'hFFFF_FFFF, 32'h8000_0001, bad[k]);
        // random sweep over every code
        for (int n = 0; n < 60; n++) begin
            foreach (ops[k]) apply($urandom, $urandom, ops[k]);
        end
        for (int n = 0; n < 40; n++) begin
            logic [31:0] r;
            r = $urandom;
            apply(r, (n % 2 == 0) ? r : {~r[31], r[30:0]}, (n % 4 < 2) ? 4'b0110 : 4'b0111);
        end
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule